// File: doc/BRIEF.md
# Dual-Channel Wiper State and Shutdown Controller

This block keeps the digital state behind two programmable resistor channels and two general-purpose logic outputs. A serial front end, not part of this block, decodes bus traffic into two kinds of one-cycle strobe. The instruction strobe carries a channel select, a midscale-reset bit, a software-shutdown bit and two logic-output values. The data strobe carries a channel select and an 8-bit tap code. The block registers these into per-channel stored codes. It then produces, for each channel, the tap code that the resistor ladder should see, a flag that opens terminal A and a flag that connects the wiper to terminal B.

Shutdown can come from two places: an active-low pin that acts without any clock, and a per-channel software flag that the instruction strobe sets. Neither source changes a stored code, so leaving shutdown brings back the previous tap setting. A software shutdown lasts only until the next instruction strobe. A read-back output always shows the stored code of the channel that the most recent instruction selected.

Top module: `wctl_top`

## Requirements
- R1: A synchronous reset (rst_n low at a clock edge) sets both stored codes to 0x80, both logic outputs to 0, all software-shutdown flags to 0 and the read-back select to channel 0.
- R2: A data strobe writes data_code into the stored code of channel data_chan. With no shutdown active, tap_code for that channel shows the new code one clock later.
- R3: An instruction strobe with instr_mrst=1 sets the stored code of channel instr_chan to 0x80.
- R4: gpo takes the value of instr_gpo only on an instruction strobe. instr_gpo[0] drives gpo[0] and instr_gpo[1] drives gpo[1]. A data strobe leaves gpo unchanged.
- R5: An instruction strobe with instr_sdn=1 places only channel instr_chan in software shutdown. That channel then shows tap_code 0x00 with a_open=1 and wiper_b=1. The other channel is unaffected.
- R6: Every instruction strobe clears all software-shutdown flags, except the flag that the same strobe sets.
- R7: While shdn_pin_n is 0, every channel shows tap_code 0x00 with a_open=1 and wiper_b=1. This takes effect combinationally, with no clock edge.
- R8: No shutdown source alters a stored code. When shutdown ends, tap_code returns to the stored code.
- R9: rd_code equals the stored code of the channel selected by the last instruction strobe, whatever the shutdown state.
- R10: An instruction with both instr_mrst and instr_sdn set loads 0x80 and enters shutdown. A later data write to that channel replaces the code but leaves the channel in shutdown.
- R11: If an instruction strobe with instr_mrst=1 and a data strobe target the same channel in the same cycle, the data code is stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| shdn_pin_n | input | 1 | Asynchronous active-low shutdown for all channels |
| instr_valid | input | 1 | Instruction strobe, one cycle |
| instr_chan | input | 1 | Channel addressed by the instruction |
| instr_mrst | input | 1 | Midscale reset of the addressed channel |
| instr_sdn | input | 1 | Software shutdown of the addressed channel |
| instr_gpo | input | 2 | New logic output values |
| data_valid | input | 1 | Data strobe, one cycle |
| data_chan | input | 1 | Channel addressed by the data write |
| data_code | input | 8 | Tap code to store |
| tap_code | output | 16 | Effective tap codes, channel 0 in bits 7:0 |
| a_open | output | 2 | Terminal A open flag per channel |
| wiper_b | output | 2 | Wiper-to-B short flag per channel |
| gpo | output | 2 | Logic outputs |
| rd_code | output | 8 | Stored code of the last instruction-selected channel |

## Verification
Two functions can fall in the same clock cycle. A data write can coincide with an instruction strobe that resets the same channel to midscale. A pin shutdown can overlap a software shutdown or its release. The random phase drives both strobes and a toggling pin at once, with matching channels often enough to hit the collision. A bench model applies the instruction first and the data write second, and it ORs the two shutdown sources. Its per-cycle expected values for tap codes, flags and read-back judge each outcome.

// File: rtl/wctl_pkg.sv
package wctl_pkg;
    localparam int DEF_NCH    = 2;
    localparam int DEF_CODE_W = 8;
    localparam int DEF_NGPO   = 2;

    // Center tap for a code of width w: only the top bit set.
    function automatic logic [31:0] mid_code(input int w);
        return 32'd1 << (w - 1);
    endfunction
endpackage

// File: rtl/wctl_regs.sv
module wctl_regs #(
    parameter int NCH    = 2,
    parameter int CODE_W = 8,
    parameter int NGPO   = 2,
    parameter int SEL_W  = 1
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           instr_valid,
    input  logic [SEL_W-1:0]               instr_chan,
    input  logic                           instr_mrst,
    input  logic                           instr_sdn,
    input  logic [NGPO-1:0]                instr_gpo,
    input  logic                           data_valid,
    input  logic [SEL_W-1:0]               data_chan,
    input  logic [CODE_W-1:0]              data_code,
    output logic [NCH-1:0][CODE_W-1:0]     code_q,
    output logic [NCH-1:0]                 sw_sd_q,
    output logic [NGPO-1:0]                gpo_q,
    output logic [SEL_W-1:0]               sel_q
);
    localparam logic [CODE_W-1:0] MID = CODE_W'(wctl_pkg::mid_code(CODE_W));

    typedef struct packed {
        logic [NCH-1:0][CODE_W-1:0] code;
        logic [NCH-1:0]             sw_sd;
        logic [NGPO-1:0]            gpo;
        logic [SEL_W-1:0]           sel;
    } state_t;

    state_t st_q, st_d, st_rst;

    always_comb begin
        st_rst       = '0;
        for (int i = 0; i < NCH; i++) st_rst.code[i] = MID;

        st_d = st_q;
        if (instr_valid) begin
            st_d.sel   = instr_chan;
            st_d.gpo   = instr_gpo;
            st_d.sw_sd = '0;
            for (int i = 0; i < NCH; i++) begin
                if (instr_chan == SEL_W'(i)) begin
                    if (instr_sdn)  st_d.sw_sd[i] = 1'b1;
                    if (instr_mrst) st_d.code[i]  = MID;
                end
            end
        end
        // A data write is applied after the instruction, so it wins.
        if (data_valid) begin
            for (int i = 0; i < NCH; i++) begin
                if (data_chan == SEL_W'(i)) st_d.code[i] = data_code;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= st_rst;
        else        st_q <= st_d;
    end

    assign code_q  = st_q.code;
    assign sw_sd_q = st_q.sw_sd;
    assign gpo_q   = st_q.gpo;
    assign sel_q   = st_q.sel;
endmodule

// File: rtl/wctl_gate.sv
module wctl_gate #(
    parameter int CODE_W = 8
) (
    input  logic [CODE_W-1:0] code_q,
    input  logic              sw_sd,
    input  logic              shdn_pin_n,
    output logic [CODE_W-1:0] tap_code,
    output logic              a_open,
    output logic              wiper_b
);
    logic sd_any;

    always_comb begin
        sd_any   = sw_sd | ~shdn_pin_n;
        tap_code = sd_any ? '0 : code_q;
        a_open   = sd_any;
        wiper_b  = sd_any;
    end
endmodule

// File: rtl/wctl_rdmux.sv
module wctl_rdmux #(
    parameter int NCH    = 2,
    parameter int CODE_W = 8,
    parameter int SEL_W  = 1
) (
    input  logic [NCH-1:0][CODE_W-1:0] code_q,
    input  logic [SEL_W-1:0]           sel_q,
    output logic [CODE_W-1:0]          rd_code
);
    always_comb begin
        rd_code = '0;
        for (int i = 0; i < NCH; i++) begin
            if (sel_q == SEL_W'(i)) rd_code = code_q[i];
        end
    end
endmodule

// File: rtl/wctl_top.sv
module wctl_top #(
    parameter int NCH    = wctl_pkg::DEF_NCH,
    parameter int CODE_W = wctl_pkg::DEF_CODE_W,
    parameter int NGPO   = wctl_pkg::DEF_NGPO,
    localparam int SEL_W = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       shdn_pin_n,
    input  logic                       instr_valid,
    input  logic [SEL_W-1:0]           instr_chan,
    input  logic                       instr_mrst,
    input  logic                       instr_sdn,
    input  logic [NGPO-1:0]            instr_gpo,
    input  logic                       data_valid,
    input  logic [SEL_W-1:0]           data_chan,
    input  logic [CODE_W-1:0]          data_code,
    output logic [NCH-1:0][CODE_W-1:0] tap_code,
    output logic [NCH-1:0]             a_open,
    output logic [NCH-1:0]             wiper_b,
    output logic [NGPO-1:0]            gpo,
    output logic [CODE_W-1:0]          rd_code
);
    logic [NCH-1:0][CODE_W-1:0] code_q;
    logic [NCH-1:0]             sw_sd_q;
    logic [SEL_W-1:0]           sel_q;

    wctl_regs #(.NCH(NCH), .CODE_W(CODE_W), .NGPO(NGPO), .SEL_W(SEL_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .instr_valid(instr_valid),
        .instr_chan (instr_chan),
        .instr_mrst (instr_mrst),
        .instr_sdn  (instr_sdn),
        .instr_gpo  (instr_gpo),
        .data_valid (data_valid),
        .data_chan  (data_chan),
        .data_code  (data_code),
        .code_q     (code_q),
        .sw_sd_q    (sw_sd_q),
        .gpo_q      (gpo),
        .sel_q      (sel_q)
    );

    for (genvar g = 0; g < NCH; g++) begin : g_chan
        wctl_gate #(.CODE_W(CODE_W)) u_gate (
            .code_q    (code_q[g]),
            .sw_sd     (sw_sd_q[g]),
            .shdn_pin_n(shdn_pin_n),
            .tap_code  (tap_code[g]),
            .a_open    (a_open[g]),
            .wiper_b   (wiper_b[g])
        );
    end

    wctl_rdmux #(.NCH(NCH), .CODE_W(CODE_W), .SEL_W(SEL_W)) u_rd (
        .code_q (code_q),
        .sel_q  (sel_q),
        .rd_code(rd_code)
    );
endmodule

// File: rtl/wctl_chk.sv
module wctl_chk #(
    parameter int NCH    = 2,
    parameter int CODE_W = 8,
    parameter int NGPO   = 2,
    parameter int SEL_W  = 1
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       shdn_pin_n,
    input logic                       instr_valid,
    input logic [SEL_W-1:0]           instr_chan,
    input logic                       instr_mrst,
    input logic                       instr_sdn,
    input logic                       data_valid,
    input logic [SEL_W-1:0]           data_chan,
    input logic [NCH-1:0][CODE_W-1:0] tap_code,
    input logic [NCH-1:0]             a_open,
    input logic [NCH-1:0]             wiper_b,
    input logic [NGPO-1:0]            gpo,
    input logic [CODE_W-1:0]          rd_code,
    input logic [NCH-1:0][CODE_W-1:0] code_q,
    input logic [NCH-1:0]             sw_sd_q
);
    localparam logic [CODE_W-1:0] MID = CODE_W'(wctl_pkg::mid_code(CODE_W));

    p_pin_forces_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !shdn_pin_n |-> (a_open == '1 && wiper_b == '1 && tap_code == '0));

    p_gpo_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !instr_valid |=> $stable(gpo));

    p_swsd_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_valid && !instr_sdn) |=> (sw_sd_q == '0));

    p_swsd_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(sw_sd_q));

    p_code_kept_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!data_valid && !(instr_valid && instr_mrst)) |=> $stable(code_q));

    p_midscale_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_valid && instr_mrst && !(data_valid && data_chan == instr_chan))
        |=> (rd_code == MID));
endmodule

bind wctl_top wctl_chk #(.NCH(NCH), .CODE_W(CODE_W), .NGPO(NGPO), .SEL_W(SEL_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .shdn_pin_n (shdn_pin_n),
    .instr_valid(instr_valid),
    .instr_chan (instr_chan),
    .instr_mrst (instr_mrst),
    .instr_sdn  (instr_sdn),
    .data_valid (data_valid),
    .data_chan  (data_chan),
    .tap_code   (tap_code),
    .a_open     (a_open),
    .wiper_b    (wiper_b),
    .gpo        (gpo),
    .rd_code    (rd_code),
    .code_q     (code_q),
    .sw_sd_q    (sw_sd_q)
);

// File: tb/sim_wctl_top.sv
`timescale 1ns/1ps
module sim_wctl_top;
    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            shdn_pin_n = 1'b1;
    logic            instr_valid = 1'b0;
    logic            instr_chan = 1'b0;
    logic            instr_mrst = 1'b0;
    logic            instr_sdn = 1'b0;
    logic [1:0]      instr_gpo = 2'b00;
    logic            data_valid = 1'b0;
    logic            data_chan = 1'b0;
    logic [7:0]      data_code = 8'h00;
    logic [1:0][7:0] tap_code;
    logic [1:0]      a_open, wiper_b, gpo;
    logic [7:0]      rd_code;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // Bench model of the requirements
    logic [7:0] m_code [2];
    logic       m_sd   [2];
    logic [1:0] m_gpo;
    logic       m_sel;

    always #10 clk = ~clk;

    wctl_top u0 (
        .clk(clk), .rst_n(rst_n), .shdn_pin_n(shdn_pin_n),
        .instr_valid(instr_valid), .instr_chan(instr_chan), .instr_mrst(instr_mrst),
        .instr_sdn(instr_sdn), .instr_gpo(instr_gpo), .data_valid(data_valid),
        .data_chan(data_chan), .data_code(data_code), .tap_code(tap_code),
        .a_open(a_open), .wiper_b(wiper_b), .gpo(gpo), .rd_code(rd_code)
    );

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_tap(int ch);
        return (!shdn_pin_n || m_sd[ch]) ? 8'h00 : m_code[ch];
    endfunction

    function automatic logic exp_flag(int ch);
        return !shdn_pin_n || m_sd[ch];
    endfunction

    task automatic cmp_all(string req);
        for (int c = 0; c < 2; c++) begin
            chk(req, tap_code[c], exp_tap(c));
            chk(req, a_open[c], exp_flag(c));
            chk(req, wiper_b[c], exp_flag(c));
        end
        chk(req, gpo, m_gpo);
        chk(req, rd_code, m_code[m_sel]);
    endtask

    // One cycle of stimulus; drive at negedge, compare at the next negedge.
    task automatic step(input logic iv, input logic ich, input logic imr, input logic isd,
                        input logic [1:0] ig, input logic dv, input logic dch,
                        input logic [7:0] dc);
        instr_valid = iv; instr_chan = ich; instr_mrst = imr; instr_sdn = isd;
        instr_gpo = ig; data_valid = dv; data_chan = dch; data_code = dc;
        if (iv) begin
            m_sel = ich; m_gpo = ig;
            m_sd[0] = 1'b0; m_sd[1] = 1'b0;
            if (isd) m_sd[ich] = 1'b1;
            if (imr) m_code[ich] = 8'h80;
        end
        if (dv) m_code[dch] = dc;
        @(posedge clk);
        @(negedge clk);
        instr_valid = 1'b0; data_valid = 1'b0;
    endtask

    initial begin
        #(20 * 150000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        end
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        m_code[0] = 8'h80; m_code[1] = 8'h80;
        m_sd[0] = 1'b0; m_sd[1] = 1'b0; m_gpo = 2'b00; m_sel = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        cmp_all("R1");

        // R2: data writes to both channels
        step(0, 0, 0, 0, 2'b00, 1, 0, 8'h3C);
        chk("R2", tap_code[0], 8'h3C);
        step(0, 0, 0, 0, 2'b00, 1, 1, 8'hA5);
        chk("R2", tap_code[1], 8'hA5);

        // R3: midscale reset of channel 1
        step(1, 1, 1, 0, 2'b00, 0, 0, 8'h00);
        chk("R3", tap_code[1], 8'h80);
        chk("R3", rd_code, 8'h80);

        // R4: outputs follow instruction only
        step(1, 1, 0, 0, 2'b10, 0, 0, 8'h00);
        chk("R4", gpo, 2'b10);
        step(0, 0, 0, 0, 2'b01, 1, 1, 8'h77);
        chk("R4", gpo, 2'b10);

        // R5, R9: software shutdown of channel 0
        step(1, 0, 0, 1, 2'b10, 0, 0, 8'h00);
        chk("R5", tap_code[0], 8'h00);
        chk("R5", a_open, 2'b01);
        chk("R5", wiper_b, 2'b01);
        chk("R5", tap_code[1], 8'h77);
        chk("R9", rd_code, 8'h3C);

        // R6, R8: next instruction releases it and restores the code
        step(1, 1, 0, 0, 2'b10, 0, 0, 8'h00);
        chk("R6", a_open, 2'b00);
        chk("R8", tap_code[0], 8'h3C);

        // R7: pin shutdown, no clock edge involved
        #2 shdn_pin_n = 1'b0;
        #1 chk("R7", tap_code, 16'h0000);
        chk("R7", a_open, 2'b11);
        chk("R9", rd_code, 8'h77);
        shdn_pin_n = 1'b1;
        #1 chk("R8", tap_code, {8'h77, 8'h3C});
        @(negedge clk);

        // R10: reset and shutdown together, then a data write
        step(1, 0, 1, 1, 2'b00, 0, 0, 8'h00);
        chk("R10", rd_code, 8'h80);
        chk("R10", a_open, 2'b01);
        step(0, 0, 0, 0, 2'b00, 1, 0, 8'h11);
        chk("R10", rd_code, 8'h11);
        chk("R10", a_open, 2'b01);
        chk("R10", tap_code[0], 8'h00);

        // R11: same-cycle collision of midscale reset and data write
        step(1, 1, 1, 0, 2'b00, 1, 1, 8'h44);
        chk("R11", rd_code, 8'h44);
        cmp_all("R11");

        // Random phase with toggling pin
        for (int n = 0; n < 600; n++) begin
            shdn_pin_n = ($urandom % 8) != 0;
            step(($urandom % 3) == 0, 1'($urandom), ($urandom % 4) == 0, ($urandom % 3) == 0,
                 2'($urandom), ($urandom % 2) == 0, 1'($urandom), 8'($urandom));
            cmp_all("R2/R5 random");
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule